// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block turns a free-running master clock into a repeating sequence of four one-hot phase strobes, so that every four clocks form one instruction cycle. On that cycle grid it runs a two-stage pipeline. While one word executes, the next word is fetched from program memory. The block steps a byte-addressed fetch address and loads each fetched word into an execute register at the end of the cycle. During execution it raises the data-memory read strobe in the second phase and the write strobe in the fourth phase.

An external execute unit decodes the word in the execute register. When that word changes the flow of control, the unit raises a taken flag with a destination address in the fourth phase. The sequencer then discards the word it fetched in that cycle and executes a NOP in its place while it fetches from the destination. A taken jump therefore costs two instruction cycles, and all other words retire one per instruction cycle. A retire pulse with the retired word's address lets the surrounding logic count cycles per instruction.

Top module: `quad_phase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to phase Q1 (`phase` = 4'b0001) with fetch address 0, `exec_word` equal to `NOP_WORD`, and `dmem_rd`, `dmem_wr` and `retire` low. The first instruction cycle after reset executes that NOP, so it raises no strobe and no retire.
- R2: `phase` is one-hot, with bit 0 meaning Q1, bit 1 Q2, bit 2 Q3 and bit 3 Q4. It moves Q1→Q2→Q3→Q4→Q1 on every clock.
- R3: `imem_addr` holds steady through an instruction cycle and changes only on entering Q1. Without a taken jump it grows by `PC_STEP` (2) per instruction cycle, wrapping modulo 2^`ADDR_W`.
- R4: The value of `imem_rdata` at the Q4 edge of a fetch cycle is shown on `exec_word` from the next Q1 through Q4. `exec_pc` carries the address that word was fetched from.
- R5: In an execute cycle holding a real instruction, `dmem_rd` is high in Q2 only and `dmem_wr` is high in Q4 only. Both stay low in every other phase.
- R6: `retire` is high for the single Q1 clock that follows each execute cycle holding a real instruction, and `retire_pc` gives that instruction's address. Straight-line code therefore retires one word every four clocks.
- R7: If `br_taken` is high at the Q4 edge of a real execute cycle, the next cycle fetches from `br_target` and executes `NOP_WORD` without strobes or retire. The word at `br_target` then executes in the cycle after that.
- R8: `br_taken` held high in Q1, Q2 or Q3 but low at Q4 has no effect on the fetch sequence.
- R9: `br_taken` high at the Q4 edge of a flushed (NOP) execute cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Program-memory byte address being fetched |
| imem_rdata | input | WORD_W | Program-memory word at `imem_addr` |
| br_taken | input | 1 | Execute unit: current word redirects control |
| br_target | input | ADDR_W | Execute unit: redirect destination |
| phase | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| exec_word | output | WORD_W | Word in the execute stage |
| exec_pc | output | ADDR_W | Address of the word in the execute stage |
| dmem_rd | output | 1 | Data-memory operand read strobe (Q2) |
| dmem_wr | output | 1 | Data-memory result write strobe (Q4) |
| retire | output | 1 | One-clock pulse per retired real instruction |
| retire_pc | output | ADDR_W | Address of the retired instruction |

## Verification
The bench builds the block with `ADDR_W` = 12, `WORD_W` = 16 and `NOP_WORD` = 16'hFFFF. With the 12-bit address, a jump to 12'hFFE followed by the normal step wraps the fetch address to zero within a few cycles, which covers the wrap case of R3. Because `NOP_WORD` is not zero, a flushed slot can be told apart from a cleared register, and the program-memory model never returns that value. `PC_STEP` keeps its default of 2, so every expected address matches byte addressing.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int NPHASE = 4;
  localparam int Q1 = 0;
  localparam int Q2 = 1;
  localparam int Q3 = 2;
  localparam int Q4 = 3;
  typedef logic [NPHASE-1:0] phase_t;
  localparam phase_t PHASE_RST = phase_t'(1);
endpackage

// File: rtl/qp_phase_ring.sv
module qp_phase_ring
  import qp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase_q
);
  always_ff @(posedge clk) begin
    if (rst) phase_q <= PHASE_RST;
    else     phase_q <= {phase_q[NPHASE-2:0], phase_q[NPHASE-1]};
  end
endmodule

// File: rtl/qp_fetch.sv
module qp_fetch #(
  parameter int          ADDR_W   = 16,
  parameter int          WORD_W   = 16,
  parameter int          PC_STEP  = 2,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_q4,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [WORD_W-1:0] ir,
  output logic [ADDR_W-1:0] ir_pc,
  output logic              ir_live
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic take;
  assign take = redirect & ir_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= '0;
      ir       <= NOP_WORD;
      ir_pc    <= '0;
      ir_live  <= 1'b0;
    end else if (at_q4) begin
      ir_pc    <= fetch_pc;
      ir_live  <= ~take;
      ir       <= take ? NOP_WORD : fetch_word;
      fetch_pc <= take ? redirect_addr : fetch_pc + STEP;
    end
  end
endmodule

// File: rtl/qp_strobes.sv
module qp_strobes
  import qp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_q,
  input  logic              ir_live,
  input  logic [ADDR_W-1:0] ir_pc,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              ret_stb,
  output logic [ADDR_W-1:0] ret_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      ret_stb <= 1'b0;
      ret_pc  <= '0;
    end else begin
      rd_stb  <= phase_q[Q1] & ir_live;
      wr_stb  <= phase_q[Q3] & ir_live;
      ret_stb <= phase_q[Q4] & ir_live;
      if (phase_q[Q4] & ir_live) ret_pc <= ir_pc;
    end
  end
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import qp_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          WORD_W   = 16,
  parameter int          PC_STEP  = 2,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_rdata,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic [3:0]        phase,
  output logic [WORD_W-1:0] exec_word,
  output logic [ADDR_W-1:0] exec_pc,
  output logic              dmem_rd,
  output logic              dmem_wr,
  output logic              retire,
  output logic [ADDR_W-1:0] retire_pc
);
  phase_t ph;
  logic   live;

  qp_phase_ring u_ring (
    .clk     (clk),
    .rst     (rst),
    .phase_q (ph)
  );

  qp_fetch #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .PC_STEP  (PC_STEP),
    .NOP_WORD (NOP_WORD)
  ) u_fetch (
    .clk           (clk),
    .rst           (rst),
    .at_q4         (ph[Q4]),
    .fetch_word    (imem_rdata),
    .redirect      (br_taken),
    .redirect_addr (br_target),
    .fetch_pc      (imem_addr),
    .ir            (exec_word),
    .ir_pc         (exec_pc),
    .ir_live       (live)
  );

  qp_strobes #(
    .ADDR_W (ADDR_W)
  ) u_stb (
    .clk     (clk),
    .rst     (rst),
    .phase_q (ph),
    .ir_live (live),
    .ir_pc   (exec_pc),
    .rd_stb  (dmem_rd),
    .wr_stb  (dmem_wr),
    .ret_stb (retire),
    .ret_pc  (retire_pc)
  );

  assign phase = ph;
endmodule

// File: rtl/qp_checker.sv
module qp_checker #(
  parameter int          ADDR_W   = 16,
  parameter int          WORD_W   = 16,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic [3:0]        phase,
  input logic [WORD_W-1:0] exec_word,
  input logic              dmem_rd,
  input logic              dmem_wr,
  input logic              retire
);
  // R1: reset brings back Q1, address zero and a NOP in execute
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == 4'b0001 && imem_addr == '0 && exec_word == NOP_WORD
             && !dmem_rd && !dmem_wr && !retire));

  // R2: exactly one phase strobe, Q4 wraps to Q1
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    phase[3] |=> phase[0]);

  // R3: fetch address only moves on entry to Q1
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !phase[0] |-> $stable(imem_addr));

  // R5: strobes confined to their phases
  a_r5_rd_q2: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |-> phase[1]);
  a_r5_wr_q4: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> phase[3]);

  // R6: retire only in Q1
  a_r6_retire_q1: assert property (@(posedge clk) disable iff (rst)
    retire |-> phase[0]);

  // R7: taken redirect in a live Q4 flushes and refetches
  a_r7_flush: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && dmem_wr && br_taken) |=>
      (exec_word == NOP_WORD && imem_addr == $past(br_target)));
endmodule

bind quad_phase_seq qp_checker #(
  .ADDR_W   (ADDR_W),
  .WORD_W   (WORD_W),
  .NOP_WORD (NOP_WORD)
) i_qp_checker (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .br_taken  (br_taken),
  .br_target (br_target),
  .phase     (phase),
  .exec_word (exec_word),
  .dmem_rd   (dmem_rd),
  .dmem_wr   (dmem_wr),
  .retire    (retire)
);

// File: tb/test_quad_phase_seq.sv
module test_quad_phase_seq;
  localparam int          AW  = 12;
  localparam int          WW  = 16;
  localparam logic [WW-1:0] NOP = 16'hFFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [WW-1:0] imem_rdata;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [3:0]    phase;
  logic [WW-1:0] exec_word;
  logic [AW-1:0] exec_pc;
  logic          dmem_rd, dmem_wr, retire;
  logic [AW-1:0] retire_pc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a);
    return {4'h5, a};
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  quad_phase_seq #(
    .ADDR_W   (AW),
    .WORD_W   (WW),
    .PC_STEP  (2),
    .NOP_WORD (NOP)
  ) i_quad_phase_seq (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .phase      (phase),
    .exec_word  (exec_word),
    .exec_pc    (exec_pc),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr),
    .retire     (retire),
    .retire_pc  (retire_pc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    br_taken = 1'b0;
    repeat (3) step();
    rst = 1'b0;   // now in cycle k=0 (Q1)
  endtask

  task automatic t_reset();
    apply_reset();
    check(phase == 4'b0001, "R1 phase", 32'(phase), 32'h1);
    check(imem_addr == 0, "R1 addr", 32'(imem_addr), 0);
    check(exec_word == NOP, "R1 exec_word", 32'(exec_word), 32'(NOP));
    for (int k = 0; k < 4; k++) begin
      check(!dmem_rd && !dmem_wr, "R1 no strobe in first cycle",
            {dmem_rd, dmem_wr}, 0);
      step();
    end
    check(!retire, "R1 no retire for reset NOP", 32'(retire), 0);
  endtask

  task automatic t_phase();
    apply_reset();
    for (int k = 0; k < 12; k++) begin
      check(phase == 4'(1 << (k % 4)), "R2 phase order", 32'(phase),
            32'(1 << (k % 4)));
      step();
    end
  endtask

  task automatic t_linear();
    apply_reset();
    for (int k = 0; k < 24; k++) begin
      int n = k / 4;
      int p = k % 4;
      check(imem_addr == AW'(2 * n), "R3 fetch addr", 32'(imem_addr), 32'(2 * n));
      if (n >= 1) begin
        check(exec_word == mem_word(AW'(2 * (n - 1))), "R4 exec word",
              32'(exec_word), 32'(mem_word(AW'(2 * (n - 1)))));
        check(exec_pc == AW'(2 * (n - 1)), "R4 exec pc", 32'(exec_pc),
              32'(2 * (n - 1)));
      end
      check(dmem_rd == (n >= 1 && p == 1), "R5 rd strobe", 32'(dmem_rd),
            32'(n >= 1 && p == 1));
      check(dmem_wr == (n >= 1 && p == 3), "R5 wr strobe", 32'(dmem_wr),
            32'(n >= 1 && p == 3));
      check(retire == (n >= 2 && p == 0), "R6 retire", 32'(retire),
            32'(n >= 2 && p == 0));
      if (n >= 2 && p == 0)
        check(retire_pc == AW'(2 * (n - 2)), "R6 retire pc", 32'(retire_pc),
              32'(2 * (n - 2)));
      step();
    end
  endtask

  task automatic t_branch();
    apply_reset();
    repeat (7) step();                    // k=7: Q4, executing word at 0
    br_taken = 1'b1; br_target = 12'hFFE;
    step();                               // k=8
    br_taken = 1'b0;
    check(imem_addr == 12'hFFE, "R7 fetch target", 32'(imem_addr), 32'hFFE);
    check(exec_word == NOP, "R7 flushed NOP", 32'(exec_word), 32'(NOP));
    check(retire && retire_pc == 0, "R7 jump itself retires", 32'(retire_pc), 0);
    step();                               // k=9
    check(!dmem_rd, "R7 no rd in flushed slot", 32'(dmem_rd), 0);
    repeat (2) step();                    // k=11
    check(!dmem_wr, "R7 no wr in flushed slot", 32'(dmem_wr), 0);
    step();                               // k=12
    check(!retire, "R7 flushed slot not retired", 32'(retire), 0);
    check(exec_word == mem_word(12'hFFE), "R7 target executes",
          32'(exec_word), 32'(mem_word(12'hFFE)));
    check(imem_addr == 12'h000, "R3 address wrap", 32'(imem_addr), 0);
    step();                               // k=13
    check(dmem_rd, "R7 rd back after flush", 32'(dmem_rd), 1);
    repeat (3) step();                    // k=16
    check(retire && retire_pc == 12'hFFE, "R7 target retires",
          32'(retire_pc), 32'hFFE);
  endtask

  task automatic t_not_q4();
    apply_reset();
    repeat (4) step();                    // k=4: Q1 of cycle 1
    br_taken = 1'b1; br_target = 12'h100;
    repeat (3) step();                    // k=7: Q4
    br_taken = 1'b0;
    step();                               // k=8
    check(imem_addr == 12'h004, "R8 early flag ignored", 32'(imem_addr), 32'h4);
    check(exec_word == mem_word(12'h002), "R8 no flush",
          32'(exec_word), 32'(mem_word(12'h002)));
  endtask

  task automatic t_dead_slot();
    apply_reset();
    repeat (7) step();                    // k=7
    br_taken = 1'b1; br_target = 12'h040;
    step();                               // k=8
    br_taken = 1'b0;
    repeat (3) step();                    // k=11: Q4 of flushed slot
    br_taken = 1'b1; br_target = 12'h080;
    step();                               // k=12
    br_taken = 1'b0;
    check(imem_addr == 12'h042, "R9 flag in NOP slot ignored",
          32'(imem_addr), 32'h42);
    check(exec_word == mem_word(12'h040), "R9 target runs",
          32'(exec_word), 32'(mem_word(12'h040)));
  endtask

  task automatic t_midrun_reset();
    apply_reset();
    repeat (10) step();
    apply_reset();
    check(phase == 4'b0001 && imem_addr == 0 && exec_word == NOP,
          "R1 reset mid-run", {phase, 16'(imem_addr)}, 32'h1_0000);
  endtask

  initial begin
    t_reset();
    t_phase();
    t_linear();
    t_branch();
    t_not_q4();
    t_dead_slot();
    t_midrun_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule